// File: doc/BRIEF.md
# Ethernet MAC Interrupt Status Aggregator

This block gathers the interrupt causes of an Ethernet MAC into one 32-bit status word and one 32-bit enable word. The upper half of the status word belongs to the transmit direction and the lower half to the receive direction. The transmit and receive engines raise causes with single-cycle pulses. Software reads both words, clears causes by writing ones to the status word, and rewrites the enable word.

Each half has a summary bit at its top position. The summary bit is recomputed from that half's three cause bits, each gated by its own enable bit. Each direction drives a level interrupt line. That line is the summary bit gated again by the enable bit at the summary position.

A soft-reset input clears both words and drops both lines. Cause events win over a software clear in the same cycle. The interrupt lines and the read data are registered.

Top module: `mac_irq_agg`

## Requirements
- R1: After a synchronous reset the status word, the enable word, rd_data, irq_tx and irq_rx are all zero.
- R2: Status bit 31 (transmit summary) is 1 exactly when any of status bits 16 (transmit complete), 17 (no transmit descriptor) and 18 (transmit bus error) is 1 together with the enable bit at the same position.
- R3: Status bit 15 (receive summary) is 1 exactly when any of status bits 0 (good frame received), 1 (no receive descriptor) and 2 (receive bus error) is 1 together with the enable bit at the same position.
- R4: irq_tx equals status bit 31 AND enable bit 31, and irq_rx equals status bit 15 AND enable bit 15. Both lines take their new value at the clock edge that samples the event or register write causing the change.
- R5: A write with reg_sel=0 clears every status cause bit written as 1 and leaves the others unchanged. Writing a 1 to a summary bit has no lasting effect. Summaries and lines are then re-evaluated.
- R6: A write with reg_sel=1 stores all 32 bits of the enable word. Both summaries and both lines are re-evaluated against the new value at the same edge.
- R7: soft_rst=1 clears the status and enable words and forces both lines low at the next edge. It takes priority over events and writes in that cycle, and leaves rd_data unchanged.
- R8: When an event pulse and a write-1-to-clear hit the same cause bit in one cycle, the bit ends up set.
- R9: tx_evt bits 0, 1 and 2 set status bits 16, 17 and 18. rx_evt bits 0, 1 and 2 set status bits 0, 1 and 2. All other status bits except the two summaries always read 0.
- R10: reg_rd=1 loads rd_data at the next edge with the status word (reg_sel=0) or the enable word (reg_sel=1), as they stood before that edge. Otherwise rd_data holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst | input | 1 | Soft reset of both words and both lines |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 1 | 0 selects the status word, 1 selects the enable word |
| reg_wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| tx_evt | input | 3 | Transmit cause pulses: complete, no descriptor, bus error |
| rx_evt | input | 3 | Receive cause pulses: good frame, no descriptor, bus error |
| irq_tx | output | 1 | Transmit interrupt level |
| irq_rx | output | 1 | Receive interrupt level |

## Verification
The directed patterns include a cause raised while its enable is off. Another enables a cause but not the summary position, which separates the summary bit from the line. Enables are also changed while causes are pending, which shows that an enable write alone re-evaluates the lines. Further patterns clear a bit in the same cycle as its event, write a 1 to a summary bit, and apply a soft reset during a burst of events. A long random phase mixes all strobes and reads. It exposes any wrong cross-coupling between the halves and any edge where the registered lines or read data fall out of step.

// File: rtl/mac_irq_pkg.sv
package mac_irq_pkg;
  // cause index inside each half of the status word
  localparam int CAUSE_DONE   = 0;  // tx complete / rx good frame
  localparam int CAUSE_NODESC = 1;  // descriptor not available
  localparam int CAUSE_BUSERR = 2;  // bus error
  localparam int NUM_CAUSE    = 3;
  // half index inside the status word
  localparam int HALF_RX = 0;
  localparam int HALF_TX = 1;
endpackage

// File: rtl/mac_irq_half.sv
module mac_irq_half #(
  parameter int HALF_W  = 16,
  parameter int N_CAUSE = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               soft_rst,
  input  logic [N_CAUSE-1:0] evt,
  input  logic               clr_wr,
  input  logic [N_CAUSE-1:0] clr_mask,
  input  logic [N_CAUSE-1:0] en_cause,
  input  logic               en_sum,
  output logic [HALF_W-1:0]  status,
  output logic               irq
);
  localparam int SUM_POS = HALF_W - 1;

  logic [N_CAUSE-1:0] cause_q, cause_d;
  logic               sum_q, sum_d;

  genvar g;
  generate
    for (g = 0; g < N_CAUSE; g++) begin : g_cause
      // set wins over clear
      assign cause_d[g] = (cause_q[g] & ~(clr_wr & clr_mask[g])) | evt[g];

      // R9
      set_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (evt[g] && !soft_rst) |=> cause_q[g]);
      // R5
      w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_wr && clr_mask[g] && !evt[g] && !soft_rst) |=> !cause_q[g]);
      // R8
      set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_wr && clr_mask[g] && evt[g] && !soft_rst) |=> cause_q[g]);
    end
  endgenerate

  assign sum_d = |(cause_d & en_cause);

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      cause_q <= '0;
      sum_q   <= 1'b0;
      irq     <= 1'b0;
    end else begin
      cause_q <= cause_d;
      sum_q   <= sum_d;
      irq     <= sum_d & en_sum;
    end
  end

  always_comb begin
    status                 = '0;
    status[N_CAUSE-1:0]    = cause_q;
    status[SUM_POS]        = sum_q;
  end

  // R7
  soft_drop_chk: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (cause_q == '0 && !sum_q && !irq));
  // R4
  irq_needs_sum_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> sum_q);
endmodule

// File: rtl/mac_irq_agg.sv
module mac_irq_agg
  import mac_irq_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int N_CAUSE = NUM_CAUSE
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               soft_rst,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic               reg_sel,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  rd_data,
  input  logic [N_CAUSE-1:0] tx_evt,
  input  logic [N_CAUSE-1:0] rx_evt,
  output logic               irq_tx,
  output logic               irq_rx
);
  localparam int HALF_W  = DATA_W / 2;
  localparam int N_HALF  = 2;
  localparam int SUM_OFS = HALF_W - 1;

  logic [DATA_W-1:0]                en_q, en_d;
  logic [N_HALF-1:0][HALF_W-1:0]    status_h;
  logic [N_HALF-1:0][N_CAUSE-1:0]   evt_h;
  logic [N_HALF-1:0]                irq_h;
  logic [DATA_W-1:0]                status_w;
  logic                             stat_wr;

  assign evt_h[HALF_TX] = tx_evt;
  assign evt_h[HALF_RX] = rx_evt;
  assign stat_wr        = reg_wr & ~reg_sel;
  assign en_d           = (reg_wr && reg_sel) ? reg_wdata : en_q;
  assign status_w       = status_h;

  always_ff @(posedge clk) begin
    if (rst || soft_rst) en_q <= '0;
    else                 en_q <= en_d;
  end

  genvar h;
  generate
    for (h = 0; h < N_HALF; h++) begin : g_half
      mac_irq_half #(
        .HALF_W (HALF_W),
        .N_CAUSE(N_CAUSE)
      ) u_half (
        .clk     (clk),
        .rst     (rst),
        .soft_rst(soft_rst),
        .evt     (evt_h[h]),
        .clr_wr  (stat_wr),
        .clr_mask(reg_wdata[h*HALF_W +: N_CAUSE]),
        .en_cause(en_d[h*HALF_W +: N_CAUSE]),
        .en_sum  (en_d[h*HALF_W + SUM_OFS]),
        .status  (status_h[h]),
        .irq     (irq_h[h])
      );
    end
  endgenerate

  assign irq_tx = irq_h[HALF_TX];
  assign irq_rx = irq_h[HALF_RX];

  always_ff @(posedge clk) begin
    if (rst)                     rd_data <= '0;
    else if (reg_rd && !soft_rst) rd_data <= reg_sel ? en_q : status_w;
  end

  // R2
  tx_sum_chk: assert property (@(posedge clk) disable iff (rst)
    status_w[DATA_W-1] == |(status_w[HALF_W +: N_CAUSE] & en_q[HALF_W +: N_CAUSE]));
  // R3
  rx_sum_chk: assert property (@(posedge clk) disable iff (rst)
    status_w[SUM_OFS] == |(status_w[N_CAUSE-1:0] & en_q[N_CAUSE-1:0]));
  // R4
  tx_line_chk: assert property (@(posedge clk) disable iff (rst)
    irq_tx == (status_w[DATA_W-1] & en_q[DATA_W-1]));
  // R4
  rx_line_chk: assert property (@(posedge clk) disable iff (rst)
    irq_rx == (status_w[SUM_OFS] & en_q[SUM_OFS]));
  // R6
  en_store_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_sel && !soft_rst) |=> en_q == $past(reg_wdata));
  // R10
  rd_stat_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && !reg_sel && !soft_rst) |=> rd_data == $past(status_w));
endmodule

// File: tb/mac_irq_agg_test.sv
`timescale 1ns/1ps
module mac_irq_agg_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        soft_rst = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0, reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] rd_data;
  logic [2:0]  tx_evt = '0, rx_evt = '0;
  logic        irq_tx, irq_rx;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  mac_irq_agg uut (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .rd_data(rd_data), .tx_evt(tx_evt), .rx_evt(rx_evt),
    .irq_tx(irq_tx), .irq_rx(irq_rx));

  // behavioural reference model
  logic [31:0] m_cause = '0, m_en = '0, m_rd = '0;
  logic        m_itx = 0, m_irx = 0;

  function automatic logic [31:0] m_word();
    logic txs, rxs;
    txs = |(m_cause[18:16] & m_en[18:16]);
    rxs = |(m_cause[2:0] & m_en[2:0]);
    return m_cause | ({31'd0, txs} << 31) | ({31'd0, rxs} << 15);
  endfunction

  always @(posedge clk) begin
    logic [31:0] w;
    if (rst) begin
      m_cause = '0; m_en = '0; m_rd = '0; m_itx = 0; m_irx = 0;
    end else if (soft_rst) begin
      m_cause = '0; m_en = '0; m_itx = 0; m_irx = 0;
    end else begin
      if (reg_rd) m_rd = reg_sel ? m_en : m_word();
      if (reg_wr && !reg_sel) m_cause = m_cause & ~reg_wdata;
      if (reg_wr && reg_sel)  m_en = reg_wdata;
      m_cause = m_cause | ({29'd0, tx_evt} << 16) | {29'd0, rx_evt};
      w = m_word();
      m_itx = w[31] & m_en[31];
      m_irx = w[15] & m_en[15];
    end
  end

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic cmp_all(string tag);
    chk(tag, "irq_tx", {31'd0, irq_tx}, {31'd0, m_itx});
    chk(tag, "irq_rx", {31'd0, irq_rx}, {31'd0, m_irx});
    chk(tag, "rd_data", rd_data, m_rd);
  endtask

  // one clock: drive at negedge, compare at the next negedge
  task automatic cyc(string tag, logic wr, logic rd, logic sel, logic [31:0] wd,
                     logic [2:0] te, logic [2:0] re, logic sr);
    reg_wr = wr; reg_rd = rd; reg_sel = sel; reg_wdata = wd;
    tx_evt = te; rx_evt = re; soft_rst = sr;
    @(negedge clk);
    cmp_all(tag);
    reg_wr = 0; reg_rd = 0; soft_rst = 0; tx_evt = '0; rx_evt = '0;
  endtask

  task automatic rd_status(string tag, logic [31:0] exp);
    cyc(tag, 0, 1, 0, '0, '0, '0, 0);
    chk(tag, "status read", rd_data, exp);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1", "irq_tx", {31'd0, irq_tx}, 32'd0);
    rd_status("R1", 32'h0);
    cyc("R1", 0, 1, 1, '0, '0, '0, 0);
    chk("R1", "enable read", rd_data, 32'h0);
    // R9 / R2: cause enabled, summary set, line held off (R4)
    cyc("R6", 1, 0, 1, 32'h0001_0000, '0, '0, 0);
    cyc("R9", 0, 0, 0, '0, 3'b001, '0, 0);
    chk("R4", "irq_tx off", {31'd0, irq_tx}, 32'd0);
    rd_status("R2", 32'h8001_0000);
    // R6: enable summary position raises line at that edge
    cyc("R6", 1, 0, 1, 32'h8001_0000, '0, '0, 0);
    chk("R6", "irq_tx on", {31'd0, irq_tx}, 32'd1);
    // R5: clear
    cyc("R5", 1, 0, 0, 32'h0001_0000, '0, '0, 0);
    chk("R5", "irq_tx cleared", {31'd0, irq_tx}, 32'd0);
    rd_status("R5", 32'h0);
    // R8: set beats clear
    cyc("R8", 1, 0, 0, 32'h0001_0000, 3'b001, '0, 0);
    chk("R8", "irq_tx", {31'd0, irq_tx}, 32'd1);
    rd_status("R8", 32'h8001_0000);
    // R5: writing summary bit has no effect
    cyc("R5", 1, 0, 0, 32'h8000_0000, '0, '0, 0);
    rd_status("R5", 32'h8001_0000);
    // R3 / R6: enable change drops tx line, rx cause without enable
    cyc("R6", 1, 0, 1, 32'h0000_8006, '0, '0, 0);
    chk("R6", "irq_tx dropped", {31'd0, irq_tx}, 32'd0);
    cyc("R3", 0, 0, 0, '0, '0, 3'b001, 0);
    chk("R3", "irq_rx off", {31'd0, irq_rx}, 32'd0);
    rd_status("R3", 32'h0001_0001);
    cyc("R3", 0, 0, 0, '0, '0, 3'b100, 0);
    chk("R3", "irq_rx on", {31'd0, irq_rx}, 32'd1);
    rd_status("R3", 32'h0001_8005);
    // R9: unlisted bits stay zero, enable stores all bits
    cyc("R9", 1, 0, 1, 32'hFFFF_FFFF, '0, '0, 0);
    rd_status("R9", 32'h8001_8005);
    cyc("R10", 0, 1, 1, '0, '0, '0, 0);
    chk("R10", "enable read", rd_data, 32'hFFFF_FFFF);
    // R7: soft reset wins over events
    cyc("R7", 1, 0, 1, 32'h1234_5678, 3'b111, 3'b111, 1);
    chk("R7", "irq_tx", {31'd0, irq_tx}, 32'd0);
    chk("R7", "irq_rx", {31'd0, irq_rx}, 32'd0);
    chk("R7", "rd_data held", rd_data, 32'hFFFF_FFFF);
    rd_status("R7", 32'h0);
    cyc("R7", 0, 1, 1, '0, '0, '0, 0);
    chk("R7", "enable read", rd_data, 32'h0);
    // R2: descriptor-unavailable cause
    cyc("R2", 1, 0, 1, 32'h8002_0000, '0, '0, 0);
    cyc("R2", 0, 0, 0, '0, 3'b010, '0, 0);
    chk("R2", "irq_tx", {31'd0, irq_tx}, 32'd1);
    // random mix, compared every clock (R10 and all others)
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      r = $urandom;
      cyc("R10", r[0] & r[1], r[2], r[3],
          r[4] ? $urandom : (r[5] ? 32'h8007_8007 : 32'hFFFF_FFFF),
          r[8] ? r[11:9] : 3'b0, r[12] ? r[15:13] : 3'b0,
          (r[23:16] == 8'd0));
    end
    done = 1;
    finish_run();
  end
endmodule